// File: doc/BRIEF.md
# Late-arrival detecting pipeline register with in-place recovery

This block is a bank of pipeline register bits, each backed by a second copy that samples the same input later than the main capture. The late copy is modelled here as a separate input, `late_in`, which gives the value the data line settled to after the clock edge. The block compares the two copies bit by bit on every normal capture. Any bit where they differ marks a timing error. Those per-bit flags are combined into one recovery strobe.

When the strobe is up, the block spends one recovery cycle. In that cycle the main register is refilled from the late copy, and the late copy is frozen so that its contents stay intact. Incoming data is dropped during the recovery cycle. The upstream logic is expected to use the strobe to stall or to bubble that slot. The net cost of an error is one cycle, and no recomputation is needed.

A separate fail output is raised when the surrounding circuitry marks a late sample as ambiguous. The pipeline owner treats that as a cue to flush everything.

Top module: `late_capture_bank`

## Requirements
- R1: A synchronous active-high `rst` clears the main copy, the late copy, `err_bits`, `restore` and `fail`. All outputs read zero in the cycle after a reset edge.
- R2: In a normal cycle (restore low), the clock edge loads `data_in` into the main copy. `data_out` shows it one cycle later.
- R3: In a normal cycle, bit i of `err_bits` becomes `data_in[i] XOR late_in[i]`, registered at the same edge as the capture.
- R4: `restore` is the OR of all `err_bits` and is registered at the same edge.
- R5: At the edge that ends a recovery cycle (restore high), the main copy is loaded from the late copy. `data_out` then equals the `late_in` value captured with the erroneous word.
- R6: During a recovery cycle the late copy does not capture. `data_in`, `late_in` and `ambig_in` are ignored, so `data_out` after recovery does not depend on them.
- R7: `restore` never stays high for two cycles in a row. Errors on every normal capture give one recovery cycle after each, which halves throughput.
- R8: In a normal cycle, `fail` becomes the OR of `ambig_in` and lasts one cycle. During a recovery cycle `fail` is driven low.
- R9: After a recovery cycle, all `err_bits` are zero. Errors that arrive during recovery are not flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | WIDTH | Data captured at the main clock edge |
| late_in | input | WIDTH | Same data as sampled later in the cycle |
| ambig_in | input | WIDTH | Per-bit mark that the late sample was ambiguous |
| data_out | output | WIDTH | Main register contents |
| err_bits | output | WIDTH | Registered per-bit mismatch flags |
| restore | output | 1 | Recovery strobe, high for the single recovery cycle |
| fail | output | 1 | Detection-unreliable flag, one cycle |

## Verification
The bound checker checks the following properties on every cycle:
- `restore` always equals the OR of the error bits.
- A recovery cycle is never followed by another.
- The error bits are empty after recovery.
- The late copy holds still across recovery, and the main copy reloads from it.
- Error bits and `fail` follow the previous inputs in normal cycles.

Only the bench's scenarios can show two things. First, the recovered word equals the late value of the failing capture even when the recovery-cycle inputs are hostile. Second, alternating errors really produce the half-rate error/recover pattern. The bench uses directed cases for error bits at both ends of the word and for reset in mid-run.

// File: rtl/late_capture_pkg.sv
package late_capture_pkg;
  typedef enum logic {
    PH_CAPTURE = 1'b0,
    PH_RECOVER = 1'b1
  } phase_e;
endpackage

// File: rtl/late_capture_cell.sv
module late_capture_cell (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic d,
  input  logic d_late,
  output logic mismatch,
  output logic q,
  output logic shadow,
  output logic err_q
);
  // Mismatch of the pair being written this edge.
  assign mismatch = d ^ d_late;

  always_ff @(posedge clk) begin
    if (rst) begin
      q      <= 1'b0;
      shadow <= 1'b0;
      err_q  <= 1'b0;
    end else if (hold) begin
      // Recovery: refill main from late copy, freeze late copy.
      q     <= shadow;
      err_q <= 1'b0;
    end else begin
      q      <= d;
      shadow <= d_late;
      err_q  <= mismatch;
    end
  end
endmodule

// File: rtl/late_capture_ctl.sv
module late_capture_ctl
  import late_capture_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] mismatch,
  input  logic [WIDTH-1:0] ambig,
  output logic             restore,
  output logic             fail
);
  phase_e phase_q;
  logic   fail_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_CAPTURE;
      fail_q  <= 1'b0;
    end else if (phase_q == PH_RECOVER) begin
      // Detection re-armed only here; errors in this cycle are dropped.
      phase_q <= PH_CAPTURE;
      fail_q  <= 1'b0;
    end else begin
      phase_q <= (|mismatch) ? PH_RECOVER : PH_CAPTURE;
      fail_q  <= |ambig;
    end
  end

  assign restore = (phase_q == PH_RECOVER);
  assign fail    = fail_q;
endmodule

// File: rtl/late_capture_bank.sv
module late_capture_bank #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] data_in,
  input  logic [WIDTH-1:0] late_in,
  input  logic [WIDTH-1:0] ambig_in,
  output logic [WIDTH-1:0] data_out,
  output logic [WIDTH-1:0] err_bits,
  output logic             restore,
  output logic             fail
);
  logic [WIDTH-1:0] mismatch_w;
  logic [WIDTH-1:0] shadow_w;
  logic             hold_w;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    late_capture_cell cell_i (
      .clk      (clk),
      .rst      (rst),
      .hold     (hold_w),
      .d        (data_in[i]),
      .d_late   (late_in[i]),
      .mismatch (mismatch_w[i]),
      .q        (data_out[i]),
      .shadow   (shadow_w[i]),
      .err_q    (err_bits[i])
    );
  end

  late_capture_ctl #(.WIDTH(WIDTH)) ctl_i (
    .clk      (clk),
    .rst      (rst),
    .mismatch (mismatch_w),
    .ambig    (ambig_in),
    .restore  (hold_w),
    .fail     (fail)
  );

  assign restore = hold_w;
endmodule

// File: rtl/late_capture_bank_chk.sv
module late_capture_bank_chk #(
  parameter int WIDTH = 64
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] data_in,
  input logic [WIDTH-1:0] late_in,
  input logic [WIDTH-1:0] ambig_in,
  input logic [WIDTH-1:0] data_out,
  input logic [WIDTH-1:0] err_bits,
  input logic [WIDTH-1:0] shadow,
  input logic             restore,
  input logic             fail
);
  a_r4_restore_or: assert property (@(posedge clk) disable iff (rst)
    restore == (|err_bits));
  a_r7_no_double: assert property (@(posedge clk) disable iff (rst)
    restore |=> !restore);
  a_r9_err_clear: assert property (@(posedge clk) disable iff (rst)
    restore |=> (err_bits == '0));
  a_r5_reload: assert property (@(posedge clk) disable iff (rst)
    restore |=> (data_out == $past(shadow)));
  a_r6_shadow_frozen: assert property (@(posedge clk) disable iff (rst)
    restore |=> $stable(shadow));
  a_r3_err_follow: assert property (@(posedge clk) disable iff (rst)
    !restore |=> (err_bits == $past(data_in ^ late_in)));
  a_r8_fail_follow: assert property (@(posedge clk) disable iff (rst)
    !restore |=> (fail == $past(|ambig_in)));
endmodule

bind late_capture_bank late_capture_bank_chk #(.WIDTH(WIDTH)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .data_in  (data_in),
  .late_in  (late_in),
  .ambig_in (ambig_in),
  .data_out (data_out),
  .err_bits (err_bits),
  .shadow   (shadow_w),
  .restore  (restore),
  .fail     (fail)
);

// File: tb/late_capture_bank_tb_top.sv
`timescale 1ns/1ps
module late_capture_bank_tb_top;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] data_in = '0, late_in = '0, ambig_in = '0;
  logic [W-1:0] data_out, err_bits;
  logic         restore, fail;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state
  logic [W-1:0] m_q = '0, m_s = '0, m_e = '0;
  logic         m_r = 1'b0, m_f = 1'b0, prev_r = 1'b0;

  always #2 clk = ~clk;

  late_capture_bank #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .data_in(data_in), .late_in(late_in),
    .ambig_in(ambig_in), .data_out(data_out), .err_bits(err_bits),
    .restore(restore), .fail(fail)
  );

  function automatic logic [W-1:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: drive at negedge, update model at posedge, check just after.
  task automatic step(input logic r, input logic [W-1:0] d, input logic [W-1:0] dl,
                      input logic [W-1:0] am);
    @(negedge clk);
    rst = r; data_in = d; late_in = dl; ambig_in = am;
    @(posedge clk);
    prev_r = m_r;
    if (r) begin
      m_q = '0; m_s = '0; m_e = '0; m_r = 1'b0; m_f = 1'b0;
    end else if (m_r) begin
      m_q = m_s; m_e = '0; m_r = 1'b0; m_f = 1'b0;
    end else begin
      m_q = d; m_s = dl; m_e = d ^ dl; m_r = |(d ^ dl); m_f = |am;
    end
    #1;
    if (r) begin
      chk("R1 data_out", data_out, '0);
      chk("R1 err_bits", err_bits, '0);
      chk("R1 restore", W'(restore), '0);
      chk("R1 fail", W'(fail), '0);
    end else begin
      chk(prev_r ? "R5 R6 data_out after recovery" : "R2 data_out", data_out, m_q);
      chk(prev_r ? "R9 err_bits" : "R3 err_bits", err_bits, m_e);
      chk(prev_r ? "R7 restore" : "R4 restore", W'(restore), W'(m_r));
      chk("R8 fail", W'(fail), W'(m_f));
    end
  endtask

  initial begin
    step(1, rnd64(), rnd64(), rnd64());   // R1 reset
    step(1, '0, '0, '0);
    // R2: clean captures
    step(0, 64'h0123_4567_89ab_cdef, 64'h0123_4567_89ab_cdef, '0);
    step(0, '1, '1, '0);
    // R3 R4 R5: error on bit 0, R6: hostile inputs during recovery
    step(0, 64'h5, 64'h4, '0);
    step(0, rnd64(), rnd64(), '1);
    step(0, 64'h77, 64'h77, '0);
    // error on top bit
    step(0, 64'h8000_0000_0000_0000, '0, '0);
    step(0, '1, '0, '0);
    step(0, '0, '0, '0);
    // R7: back-to-back errors, half rate
    for (int k = 0; k < 6; k++) step(0, rnd64(), rnd64(), '0);
    // R8: fail in normal cycle
    step(0, 64'h9, 64'h9, 64'h100);
    step(0, 64'ha, 64'ha, '0);
    // random mix, with a mid-run reset
    for (int k = 0; k < 600; k++) begin
      logic [W-1:0] d, dl, am;
      d  = rnd64();
      dl = ($urandom_range(0, 3) == 0) ? (d ^ (64'h1 << $urandom_range(0, W-1))) : d;
      am = ($urandom_range(0, 15) == 0) ? rnd64() : '0;
      step(k == 300, d, dl, am);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule